// File: doc/BRIEF.md
# Cumulative Assertion Time Accumulator

This block measures how long an active-low over-temperature pin has been held low, adding the time across separate assertions into one 8-bit total. The pin is synchronized on entry. An internal period counter sets the time unit of one count (`TICK_CYCLES` clock cycles; the default suits roughly 22.76 ms per count at 100 MHz). Part-periods round up, so any assertion, however short, adds at least one count. The total stops at 255 and does not wrap.

A host reads the total through a small register port, and the read clears it. If the pin is still low when the read happens, the total restarts from one instead of zero. The total is compared with a programmable limit. When the total rises above the limit, a sticky event flag is set. An active-low, level-type alert output shows that flag unless a mask bit is set. The mask only gates the pin; the flag is still set while masked. Software clears the flag by writing one to it.

Top module: `hot_time_accum`

## Requirements
- R1: After reset the total reads 0, the limit reads 0xFF, the mask reads 0, the status reads 0 and `alert_no` is high.
- R2: One assertion that the core samples low for L clock cycles adds 1 + floor((L-1)/TICK_CYCLES) to the total. The first low cycle of each assertion counts immediately, and each further full period adds one more.
- R3: The total accumulates across separate assertions and is not restarted when a new assertion begins.
- R4: A read of address 0 returns the total and then clears it to 0 when the pin is not asserted.
- R5: A read of address 0 during an assertion returns the total and leaves it at 1. Counting then continues from there without restarting the period in progress.
- R6: The event flag (status bit 0) is set in the cycle after the total is strictly greater than the limit (address 1). A total equal to the limit does not set it.
- R7: A limit of 0 sets the flag on the first assertion.
- R8: The flag stays set until a write to address 3 with bit 0 = 1. If that write falls in a cycle where the total still exceeds the limit, the flag stays set.
- R9: With mask bit 0 (address 2) = 1, `alert_no` stays high, but the flag is still set and still reads back.
- R10: `alert_no` is low exactly while the flag is set and the mask is 0. It follows mask and flag changes as a level.
- R11: The total saturates at 0xFF.
- R12: Register map: address 0 holds the total (read-only; writes are ignored), address 1 the 8-bit limit, address 2 the mask in bit 0, and address 3 the status in bit 0. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hot_ni | input | 1 | Over-temperature pin, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read of address 0 clears the total) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| alert_no | output | 1 | Alert, active low, level |

## Verification
Two events can land in the same clock edge: a software clear of the event flag and a flag set caused by a total that still exceeds the limit. The bench provokes this by writing the clear while the total remains above the limit, and expects the flag to stay set. A second collision is a clear-on-read of the total during a running assertion. The bench reads in the middle of a held assertion, releases the pin before the next period boundary, and expects exactly 1 on the following read.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    A_TOTAL  = 2'd0,
    A_LIMIT  = 2'd1,
    A_MASK   = 2'd2,
    A_STATUS = 2'd3
  } addr_e;
endpackage

// File: rtl/accum_sync.sv
module accum_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/accum_core.sv
module accum_core #(
  parameter int TW          = 8,
  parameter int TICK_CYCLES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hot_i,
  input  logic          rd_clr_i,
  output logic [TW-1:0] total_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [TW-1:0] T_MAX = '1;

  logic          hot_q;
  logic [PW-1:0] phase_q;
  logic [TW-1:0] total_q;
  logic          start, tick_hit, inc;

  assign start    = hot_i & ~hot_q;
  assign tick_hit = hot_i & hot_q & (phase_q == PH_LAST);
  assign inc      = start | tick_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      hot_q <= hot_i;
      if (start || tick_hit) phase_q <= '0;
      else if (hot_i)        phase_q <= phase_q + 1'b1;
      else                   phase_q <= '0;
    end
  end

  // read clear wins; a read under assertion leaves one count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       total_q <= '0;
    else if (rd_clr_i)                 total_q <= {{(TW-1){1'b0}}, hot_i};
    else if (inc && total_q != T_MAX)  total_q <= total_q + 1'b1;
  end

  assign total_o = total_q;
endmodule

// File: rtl/accum_regs.sv
module accum_regs
  import accum_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] total_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] limit_o,
  output logic          mask_o,
  output logic          flag_o,
  output logic          rd_total_o,
  output logic          clr_flag_o
);
  addr_e         sel;
  logic [DW-1:0] limit_q;
  logic          mask_q, flag_q, exceed;

  assign sel        = addr_e'(addr_i);
  assign rd_total_o = rd_en_i & (sel == A_TOTAL);
  assign clr_flag_o = wr_en_i & (sel == A_STATUS) & wdata_i[0];
  assign exceed     = total_i > limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '1;
      mask_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == A_LIMIT) limit_q <= wdata_i;
      if (sel == A_MASK)  mask_q  <= wdata_i[0];
    end
  end

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (exceed)     flag_q <= 1'b1;
    else if (clr_flag_o) flag_q <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      A_TOTAL:  rdata_o = total_i;
      A_LIMIT:  rdata_o = limit_q;
      A_MASK:   rdata_o = {{(DW-1){1'b0}}, mask_q};
      A_STATUS: rdata_o = {{(DW-1){1'b0}}, flag_q};
      default:  rdata_o = '0;
    endcase
  end

  assign limit_o = limit_q;
  assign mask_o  = mask_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/hot_time_accum.sv
module hot_time_accum
  import accum_pkg::*;
#(
  parameter int TICK_CYCLES = 2276000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hot_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          alert_no
);
  logic          hot_n_s, hot_s;
  logic [DW-1:0] total_q, limit_q;
  logic          mask_q, flag_q, rd_total, clr_flag;

  accum_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(hot_ni), .sync_o(hot_n_s)
  );
  assign hot_s = ~hot_n_s;

  accum_core #(.TW(DW), .TICK_CYCLES(TICK_CYCLES)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .hot_i(hot_s),
    .rd_clr_i(rd_total), .total_o(total_q)
  );

  accum_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .total_i(total_q),
    .rdata_o(rdata_o), .limit_o(limit_q), .mask_o(mask_q), .flag_o(flag_q),
    .rd_total_o(rd_total), .clr_flag_o(clr_flag)
  );

  assign alert_no = ~(flag_q & ~mask_q);
endmodule

// File: rtl/hot_time_accum_chk.sv
module hot_time_accum_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hot_s,
  input logic       rd_total,
  input logic       clr_flag,
  input logic [7:0] total_q,
  input logic [7:0] limit_q,
  input logic       flag_q,
  input logic       mask_q,
  input logic       alert_no
);
  assert_clr_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_total && !hot_s |=> total_q == 8'd0);

  assert_clr_hot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_total && hot_s |=> total_q == 8'd1);

  assert_no_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_total |=> total_q >= $past(total_q));

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total_q > limit_q |=> flag_q);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_flag |=> flag_q);

  assert_saturate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total_q == 8'hFF && !rd_total |=> total_q == 8'hFF);

  assert_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> alert_no);

  assert_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |-> alert_no);
endmodule

bind hot_time_accum hot_time_accum_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hot_s(hot_s), .rd_total(rd_total),
  .clr_flag(clr_flag), .total_q(total_q), .limit_q(limit_q),
  .flag_q(flag_q), .mask_q(mask_q), .alert_no(alert_no)
);

// File: tb/hot_time_accum_bench.sv
module hot_time_accum_bench;
  localparam int T = 8;

  typedef struct {
    bit         is_alert;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hot_n = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, probe = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       alert_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  hot_time_accum #(.TICK_CYCLES(T)) u_hot_time_accum (
    .clk_i(clk), .rst_ni(rst_n), .hot_ni(hot_n), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .alert_no(alert_n)
  );

  // monitor: compare against the scoreboard away from the clock edge
  initial forever begin
    @(negedge clk); #2;
    if (rd_en || probe) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = it.is_alert ? {7'd0, alert_n} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string r);
    @(negedge clk); addr = a; rd_en = 1'b1; sb.push_back('{1'b0, e, r});
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_alert(input logic e, input string r);
    @(negedge clk); probe = 1'b1; sb.push_back('{1'b1, {7'd0, e}, r});
    @(negedge clk); probe = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk); hot_n = 1'b0;
    repeat (len) @(negedge clk);
    hot_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R12 reset state
    rd(2'd0, 8'h00, "R1 total");
    rd(2'd1, 8'hFF, "R1 limit");
    rd(2'd2, 8'h00, "R1 mask");
    rd(2'd3, 8'h00, "R1 status");
    chk_alert(1'b1, "R1 alert");
    // R2 rounding
    pulse(T);      rd(2'd0, 8'd1, "R2 one period");
    rd(2'd0, 8'd0, "R4 cleared");
    wr(2'd0, 8'h55); rd(2'd0, 8'd0, "R12 total read-only");
    pulse(1);      rd(2'd0, 8'd1, "R2 single cycle");
    pulse(T + 1);  rd(2'd0, 8'd2, "R2 just over one period");
    pulse(2 * T);  rd(2'd0, 8'd2, "R2 two periods");
    pulse(5 * T);  rd(2'd0, 8'd5, "R2 five periods");
    // R3 accumulation
    pulse(T); pulse(T); pulse(3);
    rd(2'd0, 8'd3, "R3 three pulses");
    // R5 read during assertion: read edge sees 2T+2 low cycles -> 3
    @(negedge clk); hot_n = 1'b0;
    repeat (2 * T + 3) @(negedge clk);
    rd(2'd0, 8'd3, "R5 value during assertion");
    hot_n = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd0, 8'd1, "R5 restarts at one");
    // R6 limit compare
    wr(2'd1, 8'd2); rd(2'd1, 8'd2, "R12 limit readback");
    pulse(2 * T);
    rd(2'd3, 8'd0, "R6 equal does not set");
    rd(2'd0, 8'd2, "R6 total at limit");
    pulse(3 * T);
    rd(2'd3, 8'd1, "R6 exceed sets flag");
    chk_alert(1'b0, "R10 alert low");
    rd(2'd0, 8'd3, "R6 total above limit");
    rd(2'd3, 8'd1, "R8 sticky after read");
    wr(2'd3, 8'd1);
    rd(2'd3, 8'd0, "R8 cleared by write");
    chk_alert(1'b1, "R10 alert released");
    // R8 collision: clear while still exceeding
    pulse(3 * T);
    wr(2'd3, 8'd1);
    rd(2'd3, 8'd1, "R8 set wins over clear");
    rd(2'd0, 8'd3, "R8 total");
    wr(2'd3, 8'd1);
    rd(2'd3, 8'd0, "R8 clear after total read");
    // R7 limit zero
    wr(2'd1, 8'd0);
    pulse(1);
    rd(2'd3, 8'd1, "R7 first assertion sets flag");
    rd(2'd0, 8'd1, "R7 total");
    wr(2'd3, 8'd1);
    rd(2'd3, 8'd0, "R7 flag cleared");
    // R9 mask
    wr(2'd2, 8'd1); rd(2'd2, 8'd1, "R12 mask readback");
    pulse(1);
    rd(2'd3, 8'd1, "R9 flag set while masked");
    chk_alert(1'b1, "R9 alert suppressed");
    wr(2'd2, 8'd0);
    chk_alert(1'b0, "R10 unmask shows alert");
    rd(2'd0, 8'd1, "R9 total");
    wr(2'd3, 8'd1);
    chk_alert(1'b1, "R10 released after clear");
    // R11 saturation
    wr(2'd1, 8'hFF);
    pulse(2100);
    rd(2'd0, 8'hFF, "R11 saturated");
    rd(2'd3, 8'd0, "R11 no flag at 0xFF limit");
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule